// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction Processor Core

This block is a 32-bit processor core that retires one instruction on every rising clock edge. It handles a seven-instruction subset: register add and subtract (and a few further register-register ALU operations selected by the function field), OR with an immediate, word load, word store, branch-if-equal and an absolute jump. The core holds its own program counter, a 32-entry register file, an ALU, an immediate extender, operand and writeback multiplexers, and two word-addressed memories. One memory holds instructions and the other holds data. Control is split in two levels. A main decoder looks at the opcode and produces the datapath controls plus a 3-bit ALU operation class. A local decoder turns that class, together with the function field, into a 3-bit ALU command.

A loading port writes either memory while reset is held, so the program and the initial data are in place before execution starts. A debug port shows the program counter and reads any register without a clock. This lets an external instruction-set model compare the architectural state after every instruction.

Top module: `sc_core`

## Requirements
- R1: Reset is synchronous. While `rst` is high, the PC and every register become 0. A cycle with `ld_en` high writes `ld_data` to word `ld_addr` of the data memory (`ld_dmem`=1) or of the instruction memory (`ld_dmem`=0).
- R2: Opcode 000000 is register-register. It writes rd with rs+rt for function 100000, rs-rt for 100010, rs AND rt for 100100, rs OR rt for 100101, and (signed rs < signed rt) ? 1 : 0 for 101010. The PC then advances by 4.
- R3: Opcode 000000 with any other function value writes no register, and the PC advances by 4.
- R4: Opcode 001101 writes rt with rs OR the zero-extended 16-bit immediate in bits 15:0.
- R5: Opcode 100011 writes rt with the data word at (rs + sign-extended immediate). Opcode 101011 stores rt at that address. Both memories take the word index from address bits 9:2. Only a store writes data memory.
- R6: Opcode 000100 compares rs and rt by subtraction. When the result is zero, the next PC is PC+4+(sign-extended immediate × 4). Otherwise it is PC+4.
- R7: Opcode 000010 sets the PC to {bits 31:28 of PC+4, target in bits 25:0, 00}. It writes no register.
- R8: Register 0 always reads as 0. Writes to it are dropped.
- R9: Any opcode outside the six above writes no register and no memory, and the PC advances by 4.
- R10: `dbg_pc` shows the current PC. `dbg_rdata` shows register `dbg_sel` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Memory load strobe, honoured during reset |
| ld_dmem | input | 1 | Load target: 1 data memory, 0 instruction memory |
| ld_addr | input | 8 | Word index for the load |
| ld_data | input | 32 | Word to load |
| dbg_sel | input | 5 | Register number for the debug read |
| dbg_rdata | output | 32 | Contents of register `dbg_sel` |
| dbg_pc | output | 32 | Current program counter |

## Verification
The hardest situations to reach from the ports are a store followed by a load that aliases the same word through a different base and offset, and backward branches or jumps that land on code already executed with new register values. The bench reaches both with long instruction streams built from a seeded generator. The generator draws register numbers from a small set, so equal operands for branches and colliding addresses for loads and stores occur often, and jump targets stay inside the loaded memory. A directed program first covers zero-extension of a negative-looking immediate, writes to register 0, undefined function and opcode values, and taken, not-taken and self-loop branches.

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core #(
  parameter int MEM_WORDS = 256
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ld_en,
  input  logic                         ld_dmem,
  input  logic [$clog2(MEM_WORDS)-1:0] ld_addr,
  input  logic [31:0]                  ld_data,
  input  logic [4:0]                   dbg_sel,
  output logic [31:0]                  dbg_rdata,
  output logic [31:0]                  dbg_pc
);
  localparam int AW = $clog2(MEM_WORDS);
  localparam logic [5:0] OP_R = 6'b000000, OP_ORI = 6'b001101, OP_LW = 6'b100011,
                         OP_SW = 6'b101011, OP_BEQ = 6'b000100, OP_J = 6'b000010;
  localparam logic [2:0] AOP_R = 3'b100, AOP_OR = 3'b010, AOP_ADD = 3'b000, AOP_SUB = 3'b001;
  localparam logic [2:0] AC_ADD = 3'b000, AC_SUB = 3'b001, AC_AND = 3'b010,
                         AC_OR = 3'b110, AC_SLT = 3'b111;

  logic [31:0] imem [MEM_WORDS];
  logic [31:0] dmem [MEM_WORDS];
  logic [31:0] rf [32];
  logic [31:0] pc, instr;

  assign instr = imem[pc[AW+1:2]];

  wire [5:0]  op  = instr[31:26];
  wire [4:0]  rs  = instr[25:21];
  wire [4:0]  rt  = instr[20:16];
  wire [4:0]  rd  = instr[15:11];
  wire [5:0]  fn  = instr[5:0];
  wire [15:0] imm = instr[15:0];

  logic dst_rd, src_imm, from_mem, reg_we, mem_we, is_br, is_jmp, ext_sign;
  logic [2:0] aluop;

  always_comb begin
    {dst_rd, src_imm, from_mem, reg_we, mem_we, is_br, is_jmp, ext_sign} = '0;
    aluop = AOP_ADD;
    case (op)
      OP_R:   begin dst_rd = 1'b1; reg_we = 1'b1; aluop = AOP_R; end
      OP_ORI: begin src_imm = 1'b1; reg_we = 1'b1; aluop = AOP_OR; end
      OP_LW:  begin src_imm = 1'b1; from_mem = 1'b1; reg_we = 1'b1; ext_sign = 1'b1; end
      OP_SW:  begin src_imm = 1'b1; mem_we = 1'b1; ext_sign = 1'b1; end
      OP_BEQ: begin is_br = 1'b1; aluop = AOP_SUB; end
      OP_J:   is_jmp = 1'b1;
      default: ;
    endcase
  end

  logic [2:0] aluctr;
  logic       fn_ok;

  always_comb begin
    fn_ok  = 1'b1;
    aluctr = AC_ADD;
    if (aluop[2]) begin
      case (fn)
        6'b100000: aluctr = AC_ADD;
        6'b100010: aluctr = AC_SUB;
        6'b100100: aluctr = AC_AND;
        6'b100101: aluctr = AC_OR;
        6'b101010: aluctr = AC_SLT;
        default:   fn_ok = 1'b0;
      endcase
    end else if (aluop[1]) aluctr = AC_OR;
    else if (aluop[0])     aluctr = AC_SUB;
  end

  wire [31:0] rs_val = (rs == 5'd0) ? 32'd0 : rf[rs];
  wire [31:0] rt_val = (rt == 5'd0) ? 32'd0 : rf[rt];
  wire [31:0] ext    = ext_sign ? {{16{imm[15]}}, imm} : {16'd0, imm};
  wire [31:0] opb    = src_imm ? ext : rt_val;

  logic [31:0] alu_y;
  always_comb begin
    case (aluctr)
      AC_SUB:  alu_y = rs_val - opb;
      AC_AND:  alu_y = rs_val & opb;
      AC_OR:   alu_y = rs_val | opb;
      AC_SLT:  alu_y = {31'd0, $signed(rs_val) < $signed(opb)};
      default: alu_y = rs_val + opb;
    endcase
  end
  wire alu_zero = (alu_y == 32'd0);

  wire [31:0] wb_val = from_mem ? dmem[alu_y[AW+1:2]] : alu_y;
  wire [4:0]  wb_reg = dst_rd ? rd : rt;
  wire        wr_go  = reg_we && fn_ok && (wb_reg != 5'd0);

  wire [31:0] pc_p4 = pc + 32'd4;
  wire [31:0] br_to = pc_p4 + {{14{imm[15]}}, imm, 2'b00};
  wire [31:0] pc_nx = is_jmp ? {pc_p4[31:28], instr[25:0], 2'b00}
                    : (is_br && alu_zero) ? br_to : pc_p4;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= 32'd0;
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
      if (ld_en && ld_dmem)  dmem[ld_addr] <= ld_data;
      if (ld_en && !ld_dmem) imem[ld_addr] <= ld_data;
    end else begin
      pc <= pc_nx;
      if (wr_go)  rf[wb_reg] <= wb_val;
      if (mem_we) dmem[alu_y[AW+1:2]] <= rt_val;
    end
  end

  assign dbg_pc    = pc;
  assign dbg_rdata = (dbg_sel == 5'd0) ? 32'd0 : rf[dbg_sel];

  // R1
  reset_pc_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pc == 32'd0);
  // R5
  store_only_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (op == OP_SW && !reg_we));
  // R6
  branch_target_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == OP_BEQ && $past(rs_val) == $past(rt_val))
    |-> pc == $past(pc) + 32'd4 + {{14{$past(imm[15])}}, $past(imm), 2'b00});
  // R7
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == OP_J) |-> pc[27:0] == {$past(instr[25:0]), 2'b00});
  // R8
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst) rf[0] == 32'd0);
  // R9
  undef_op_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) != OP_R && $past(op) != OP_ORI && $past(op) != OP_LW &&
     $past(op) != OP_SW && $past(op) != OP_BEQ && $past(op) != OP_J)
    |-> pc == $past(pc) + 32'd4);
endmodule

// File: tb/test_sc_core.sv
`timescale 1ns/1ps
module test_sc_core;
  logic clk = 1'b0, rst = 1'b1, ld_en = 1'b0, ld_dmem = 1'b0;
  logic [7:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [4:0] dbg_sel = '0;
  logic [31:0] dbg_rdata, dbg_pc;

  sc_core #(.MEM_WORDS(256)) i_sc_core (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_dmem(ld_dmem), .ld_addr(ld_addr),
    .ld_data(ld_data), .dbg_sel(dbg_sel), .dbg_rdata(dbg_rdata), .dbg_pc(dbg_pc));

  always #2.5 clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;
  logic [31:0] mimem [256];
  logic [31:0] mdmem [256];
  logic [31:0] mreg [32];
  logic [31:0] mpc;
  logic [31:0] lfsr;

  function automatic logic [31:0] rtype(int s, int t, int d, logic [5:0] f);
    return {6'b000000, 5'(s), 5'(t), 5'(d), 5'd0, f};
  endfunction
  function automatic logic [31:0] itype(logic [5:0] o, int s, int t, logic [15:0] i);
    return {o, 5'(s), 5'(t), i};
  endfunction

  function automatic logic [31:0] nxt();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  function automatic string tag_of(logic [31:0] w);
    case (w[31:26])
      6'b000000: return (w[5:0] inside {6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010}) ? "R2" : "R3";
      6'b001101: return "R4";
      6'b100011, 6'b101011: return "R5";
      6'b000100: return "R6";
      6'b000010: return "R7";
      default:   return "R9";
    endcase
  endfunction

  task automatic model_step();
    logic [31:0] w, a, b, sx, res;
    bit wr;
    int dst;
    w = mimem[mpc[9:2]];
    a = mreg[w[25:21]];
    b = mreg[w[20:16]];
    sx = {{16{w[15]}}, w[15:0]};
    wr = 1'b0; dst = w[20:16]; res = '0;
    case (w[31:26])
      6'b000000: begin
        dst = w[15:11]; wr = 1'b1;
        case (w[5:0])
          6'b100000: res = a + b;
          6'b100010: res = a - b;
          6'b100100: res = a & b;
          6'b100101: res = a | b;
          6'b101010: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default:   wr = 1'b0;
        endcase
      end
      6'b001101: begin wr = 1'b1; res = a | {16'd0, w[15:0]}; end
      6'b100011: begin wr = 1'b1; res = mdmem[7'(0) + ((a + sx) >> 2) % 256]; end
      6'b101011: mdmem[((a + sx) >> 2) % 256] = b;
      default: ;
    endcase
    if (wr && dst != 0) mreg[dst] = res;
    if (w[31:26] == 6'b000010)
      mpc = {mpc[31:28] + ((mpc + 4) >> 28) - (mpc >> 28), w[25:0], 2'b00};
    else if (w[31:26] == 6'b000100 && a == b)
      mpc = mpc + 4 + (sx << 2);
    else
      mpc = mpc + 4;
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    check({req, "/R10"}, "pc", dbg_pc, mpc);
    for (int r = 0; r < 32; r++) begin
      dbg_sel = 5'(r);
      #0.05;
      check((r == 0) ? "R8" : req, $sformatf("reg %0d", r), dbg_rdata, mreg[r]);
    end
  endtask

  task automatic load_and_reset();
    rst = 1'b1;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); ld_en = 1'b1; ld_dmem = 1'b0; ld_addr = 8'(i); ld_data = mimem[i];
    end
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); ld_en = 1'b1; ld_dmem = 1'b1; ld_addr = 8'(i); ld_data = mdmem[i];
    end
    @(negedge clk); ld_en = 1'b0;
    @(negedge clk);
    mpc = '0;
    for (int r = 0; r < 32; r++) mreg[r] = '0;
    compare("R1");
    rst = 1'b0;
  endtask

  task automatic run(int steps);
    string t;
    for (int s = 0; s < steps; s++) begin
      t = tag_of(mimem[mpc[9:2]]);
      @(negedge clk);
      model_step();
      compare(t);
    end
  endtask

  function automatic logic [31:0] rand_instr();
    logic [31:0] r;
    int s, t, d;
    r = nxt();
    s = int'(r[10:8]); t = int'(r[13:11]); d = int'(r[16:14]);
    case (r[2:0])
      3'd0, 3'd7: case (r[5:3])
        3'd0: return rtype(s, t, d, 6'b100000);
        3'd1: return rtype(s, t, d, 6'b100010);
        3'd2: return rtype(s, t, d, 6'b100100);
        3'd3: return rtype(s, t, d, 6'b100101);
        3'd4, 3'd5: return rtype(s, t, d, 6'b101010);
        default: return rtype(s, t, d, 6'(r[22:17]));
      endcase
      3'd1: return itype(6'b001101, s, t, r[31:16]);
      3'd2: return itype(6'b100011, s, t, {{6{r[31]}}, r[26:17]});
      3'd3: return itype(6'b101011, s, t, {{6{r[31]}}, r[26:17]});
      3'd4: return itype(6'b000100, s & 3, t & 3, {{12{r[23]}}, r[23:20]});
      3'd5: return {6'b000010, 18'd0, r[31:24]};
      default: return {r[3] ? 6'b111111 : 6'b001000, r[25:0]};
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) begin mimem[i] = 32'hFC00_0000; mdmem[i] = 32'h1000_0000 + i; end
    mimem[0]  = itype(6'b001101, 0, 1, 16'h8000);
    mimem[1]  = itype(6'b001101, 0, 2, 16'h0005);
    mimem[2]  = rtype(1, 2, 3, 6'b100000);
    mimem[3]  = rtype(2, 1, 4, 6'b100010);
    mimem[4]  = rtype(4, 2, 5, 6'b101010);
    mimem[5]  = rtype(1, 3, 6, 6'b100100);
    mimem[6]  = rtype(1, 2, 7, 6'b100101);
    mimem[7]  = itype(6'b001101, 0, 0, 16'hFFFF);
    mimem[8]  = itype(6'b101011, 2, 3, 16'hFFFC);
    mimem[9]  = itype(6'b100011, 2, 8, 16'hFFFC);
    mimem[10] = rtype(1, 2, 9, 6'b000000);
    mimem[11] = 32'hFC12_3456;
    mimem[12] = itype(6'b000100, 1, 1, 16'h0002);
    mimem[13] = itype(6'b001101, 0, 10, 16'h1111);
    mimem[14] = itype(6'b001101, 0, 10, 16'h2222);
    mimem[15] = itype(6'b000100, 1, 2, 16'h0005);
    mimem[16] = rtype(1, 2, 0, 6'b100000);
    mimem[17] = {6'b000010, 26'd20};
    mimem[20] = itype(6'b100011, 0, 11, 16'h0040);
    mimem[21] = itype(6'b000100, 0, 0, 16'hFFFF);
    load_and_reset();
    run(30);
    for (int p = 0; p < 6; p++) begin
      lfsr = 32'h1234_5679 * (p + 3);
      for (int i = 0; i < 256; i++) begin mimem[i] = rand_instr(); mdmem[i] = nxt(); end
      load_and_reset();
      run(400);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule